// File: doc/BRIEF.md
# Bit-Oriented Code Receive Filter

This block sits on the receive side of a T1 framer. It watches the serial data-link bits that the framer extracts from each frame. A strobe marks every bit that belongs to the link, and bits without the strobe are skipped. In that stream the block finds 16-bit bit-oriented code words, each of which carries a six-bit payload. It counts how many identical code words arrive back to back. Two independent persistence filters then judge that count. One filter sets the alarm flag and loads the valid-code register. The other filter is shared by three programmable match comparators, which raise per-comparator match flags.

Every rising edge of the alarm flag or of a match flag gives a one-cycle interrupt pulse and sets a sticky status bit. Software clears a sticky bit by writing one to it. A configuration write can also carry a self-clearing reset bit. That reset returns every register of the block to its default value, but the sticky status bits keep their state.

The tracker is a two-state machine:
- `ST_HUNT`: no code is being followed.
- `ST_TRACK`: the last code is being followed and the link bits since it are counted.

Its transitions are:
- HUNT→TRACK when an accepted code arrives.
- TRACK→TRACK on the next code, whether it repeats the last one or differs from it.
- TRACK→HUNT when the receiver is disabled, or when 16 link bits pass with no code (gap expiry).
- Any state→HUNT on a soft reset.

Top module: `boc_rx_filter`

## Requirements
- R1: A code is the window `0 p5 p4 p3 p2 p1 p0 0 1 1 1 1 1 1 1 1` received first-bit-first, with p5 (the first payload bit received) as the MSB of the payload. Only bits with `fdl_en` high enter the window, whatever `fdl_bit` is in other cycles.
- R2: The valid filter select `cfg_vfilt` needs 1, 3, 5 or 7 consecutive identical codes for the values 00, 01, 10 and 11. The code event that reaches the count loads `valid_code` and sets `alarm`. `valid_code` is unchanged before that event.
- R3: The match filter select `cfg_mfilt` uses the same 1/3/5/7 encoding. `match_evt[i]` is set when the repeat count reaches the match threshold and the code equals match value i. Match value i is taken from bits `[6i+5:6i]` of `cfg_match`. This applies to any code, whether or not it has passed the valid filter.
- R4: The two filters are independent. A code can satisfy either filter while failing the other.
- R5: A code that differs from the previous one restarts the repeat count at one.
- R6: `alarm` and `match_evt` clear when the 16th enabled link bit after the last code completes without a new code. They stay set through the 15th bit. `valid_code` holds its value.
- R7: While the enable bit is 0, codes do not change `valid_code`, `alarm` or `match_evt`.
- R8: A rising `alarm` pulses `irq_alarm` for exactly one cycle. A rising `match_evt[i]` pulses `irq_match[i]` for one cycle. The pulse is visible in the cycle that follows the flag's update. `sticky[0]` records alarm events and `sticky[i+1]` records match i events.
- R9: A one in `sticky_clr[k]` clears `sticky[k]` on the next clock edge. Other sticky bits keep their value.
- R10: A write with `cfg_reset`=1 makes `reset_busy` read 1 for one cycle. On the next edge the valid code, alarm, match flags, tracker state and all configuration fields return to zero, so the receiver is disabled. `reset_busy` returns to 0 and `sticky` keeps its value.
- R11: After `rst_n`, `valid_code`, `alarm`, `match_evt`, both interrupt outputs, `sticky` and `reset_busy` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fdl_bit | input | 1 | Serial data-link bit |
| fdl_en | input | 1 | Marks a cycle that carries a data-link bit |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Receiver enable field |
| cfg_reset | input | 1 | Self-clearing soft reset field |
| cfg_vfilt | input | 2 | Valid/alarm persistence select |
| cfg_mfilt | input | 2 | Match persistence select |
| cfg_match | input | 18 | Three six-bit match values, value i in bits [6i+5:6i] |
| sticky_clr | input | 4 | Write-one-to-clear for the sticky bits |
| valid_code | output | 6 | Last code accepted by the valid filter |
| alarm | output | 1 | A code has passed the valid filter and is still being received |
| match_evt | output | 3 | Per-comparator match flags |
| irq_alarm | output | 1 | One-cycle pulse on a rising alarm |
| irq_match | output | 3 | One-cycle pulses on rising match flags |
| sticky | output | 4 | Sticky event bits: bit 0 alarm, bits 1..3 match 0..2 |
| reset_busy | output | 1 | Soft reset bit, reads 1 until it clears itself |

## Verification
The hardest point to reach from the ports is the boundary of the gap timeout. The flags must still be set after 15 idle link bits and must clear on the 16th. That needs a tracker that is really in TRACK and a bit count that is exact to the cycle. The bench gets there by sending one whole code and then a precise number of enabled zero bits. It checks the alarm between the 15th and 16th bits. A second case that is hard to reach is the filter threshold for a changing code. Here the bench sends a new payload right after a partial run of the old one, so it can check that the count really restarts rather than carrying over.

// File: rtl/boc_rx_pkg.sv
package boc_rx_pkg;

    typedef enum logic [0:0] {
        ST_HUNT,
        ST_TRACK
    } trk_state_t;

    localparam int CNT_W = 3;

    // 00 -> 1, 01 -> 3, 10 -> 5, 11 -> 7 consecutive codes
    function automatic logic [CNT_W-1:0] persist_need(input logic [1:0] sel);
        return {sel, 1'b1};
    endfunction

endpackage

// File: rtl/boc_frame_detect.sv
module boc_frame_detect #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclr,
    input  logic              bit_en,
    input  logic              bit_in,
    output logic              code_hit,
    output logic [CODE_W-1:0] code_val
);
    localparam int FLAG_W = 8;
    localparam int WIN_W  = CODE_W + FLAG_W + 2;

    logic [WIN_W-2:0] hist_q;
    logic [WIN_W-1:0] win;

    assign win      = {hist_q, bit_in};
    assign code_val = win[WIN_W-2:FLAG_W+1];
    assign code_hit = bit_en && !win[WIN_W-1] && !win[FLAG_W]
                      && (win[FLAG_W-1:0] == {FLAG_W{1'b1}});

    // History starts as all ones so no code can be seen before a full window arrives
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hist_q <= '1;
        else if (sclr)   hist_q <= '1;
        else if (bit_en) hist_q <= win[WIN_W-2:0];
    end

    assert_flag_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_hit && !sclr) |=> (hist_q[FLAG_W-1:0] == {FLAG_W{1'b1}}));

endmodule

// File: rtl/boc_persist_fsm.sv
module boc_persist_fsm
    import boc_rx_pkg::*;
#(
    parameter int CODE_W    = 6,
    parameter int GAP_BITS  = 16,
    parameter int NUM_MATCH = 3
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              sclr,
    input  logic                              enable,
    input  logic                              bit_en,
    input  logic                              code_hit,
    input  logic [CODE_W-1:0]                 code_val,
    input  logic [1:0]                        vsel,
    input  logic [1:0]                        msel,
    input  logic [NUM_MATCH-1:0][CODE_W-1:0]  match_vals,
    output logic [CODE_W-1:0]                 valid_code,
    output logic                              alarm,
    output logic [NUM_MATCH-1:0]              match_evt
);
    localparam int GAP_W = $clog2(GAP_BITS + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_BITS - 1);

    trk_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_nx;
    logic [CODE_W-1:0] last_q;
    logic [GAP_W-1:0] gap_q;
    logic             evt, same, brk;

    assign evt    = enable && code_hit;
    assign same   = (state_q == ST_TRACK) && (code_val == last_q);
    assign cnt_nx = !same ? CNT_W'(1) : ((cnt_q == '1) ? cnt_q : cnt_q + CNT_W'(1));
    assign brk    = (state_q == ST_TRACK) && enable && bit_en && !code_hit
                    && (gap_q == GAP_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:  if (evt) state_d = ST_TRACK;
            ST_TRACK: if (!enable || brk) state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    state_q <= ST_HUNT;
        else if (sclr) state_q <= ST_HUNT;
        else           state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0; last_q <= '0; gap_q <= '0;
            valid_code <= '0; alarm <= 1'b0; match_evt <= '0;
        end else if (sclr) begin
            cnt_q <= '0; last_q <= '0; gap_q <= '0;
            valid_code <= '0; alarm <= 1'b0; match_evt <= '0;
        end else if (evt) begin
            cnt_q  <= cnt_nx;
            last_q <= code_val;
            gap_q  <= '0;
            if (cnt_nx >= persist_need(vsel)) begin
                valid_code <= code_val;
                alarm      <= 1'b1;
            end
            for (int i = 0; i < NUM_MATCH; i++)
                match_evt[i] <= (cnt_nx >= persist_need(msel)) && (code_val == match_vals[i]);
        end else if (brk) begin
            cnt_q     <= '0;
            gap_q     <= '0;
            alarm     <= 1'b0;
            match_evt <= '0;
        end else if (bit_en && state_q == ST_TRACK && gap_q != GAP_LAST) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    assert_disabled_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !sclr) |=> ($stable(valid_code) && $stable(alarm) && $stable(match_evt)));

    assert_alarm_from_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(alarm) |-> $past(code_hit));

    assert_alarm_drop_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alarm) |-> ($past(sclr) || $past(gap_q) == GAP_LAST));

endmodule

// File: rtl/boc_irq_sticky.sv
module boc_irq_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flags,
    input  logic [N-1:0] clr,
    output logic [N-1:0] irq,
    output logic [N-1:0] sticky
);
    logic [N-1:0] flags_q;

    for (genvar k = 0; k < N; k++) begin : g_bit
        assign irq[k] = flags[k] && !flags_q[k];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flags_q[k] <= 1'b0;
                sticky[k]  <= 1'b0;
            end else begin
                flags_q[k] <= flags[k];
                if (irq[k])      sticky[k] <= 1'b1;
                else if (clr[k]) sticky[k] <= 1'b0;
            end
        end

        assert_irq_sets_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] |=> sticky[k]);

        assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            irq[k] |=> !irq[k]);
    end

endmodule

// File: rtl/boc_rx_filter.sv
module boc_rx_filter #(
    parameter int CODE_W    = 6,
    parameter int GAP_BITS  = 16,
    parameter int NUM_MATCH = 3
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        fdl_bit,
    input  logic                        fdl_en,
    input  logic                        cfg_we,
    input  logic                        cfg_enable,
    input  logic                        cfg_reset,
    input  logic [1:0]                  cfg_vfilt,
    input  logic [1:0]                  cfg_mfilt,
    input  logic [NUM_MATCH*CODE_W-1:0] cfg_match,
    input  logic [NUM_MATCH:0]          sticky_clr,
    output logic [CODE_W-1:0]           valid_code,
    output logic                        alarm,
    output logic [NUM_MATCH-1:0]        match_evt,
    output logic                        irq_alarm,
    output logic [NUM_MATCH-1:0]        irq_match,
    output logic [NUM_MATCH:0]          sticky,
    output logic                        reset_busy
);
    localparam int EVT_N = NUM_MATCH + 1;

    logic                              en_q, rst_q;
    logic [1:0]                        vsel_q, msel_q;
    logic [NUM_MATCH-1:0][CODE_W-1:0]  mval_q;
    logic                              code_hit;
    logic [CODE_W-1:0]                 code_val;
    logic [EVT_N-1:0]                  irq_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; rst_q <= 1'b0; vsel_q <= '0; msel_q <= '0; mval_q <= '0;
        end else if (rst_q) begin
            en_q <= 1'b0; rst_q <= 1'b0; vsel_q <= '0; msel_q <= '0; mval_q <= '0;
        end else if (cfg_we) begin
            en_q   <= cfg_enable;
            rst_q  <= cfg_reset;
            vsel_q <= cfg_vfilt;
            msel_q <= cfg_mfilt;
            mval_q <= cfg_match;
        end
    end

    assign reset_busy = rst_q;

    boc_frame_detect #(.CODE_W(CODE_W)) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclr     (rst_q),
        .bit_en   (fdl_en),
        .bit_in   (fdl_bit),
        .code_hit (code_hit),
        .code_val (code_val)
    );

    boc_persist_fsm #(.CODE_W(CODE_W), .GAP_BITS(GAP_BITS), .NUM_MATCH(NUM_MATCH)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclr       (rst_q),
        .enable     (en_q),
        .bit_en     (fdl_en),
        .code_hit   (code_hit),
        .code_val   (code_val),
        .vsel       (vsel_q),
        .msel       (msel_q),
        .match_vals (mval_q),
        .valid_code (valid_code),
        .alarm      (alarm),
        .match_evt  (match_evt)
    );

    boc_irq_sticky #(.N(EVT_N)) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags  ({match_evt, alarm}),
        .clr    (sticky_clr),
        .irq    (irq_vec),
        .sticky (sticky)
    );

    assign irq_alarm = irq_vec[0];
    assign irq_match = irq_vec[EVT_N-1:1];

    assert_reset_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |=> !rst_q);

endmodule

// File: tb/boc_rx_filter_bench.sv
`timescale 1ns/1ps
module boc_rx_filter_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fdl_bit = 1'b0, fdl_en = 1'b0;
    logic        cfg_we = 1'b0, cfg_enable = 1'b0, cfg_reset = 1'b0;
    logic [1:0]  cfg_vfilt = '0, cfg_mfilt = '0;
    logic [17:0] cfg_match = '0;
    logic [3:0]  sticky_clr = '0;
    logic [5:0]  valid_code;
    logic        alarm, irq_alarm, reset_busy;
    logic [2:0]  match_evt, irq_match;
    logic [3:0]  sticky;

    int n_checks = 0, n_fail = 0;
    logic [5:0] exp_valid = '0;
    localparam logic [17:0] MATCHES = {6'h21, 6'h12, 6'h05}; // m2, m1, m0

    always #4 clk = ~clk;

    boc_rx_filter u_boc_rx_filter (
        .clk(clk), .rst_n(rst_n), .fdl_bit(fdl_bit), .fdl_en(fdl_en),
        .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_reset(cfg_reset),
        .cfg_vfilt(cfg_vfilt), .cfg_mfilt(cfg_mfilt), .cfg_match(cfg_match),
        .sticky_clr(sticky_clr), .valid_code(valid_code), .alarm(alarm),
        .match_evt(match_evt), .irq_alarm(irq_alarm), .irq_match(irq_match),
        .sticky(sticky), .reset_busy(reset_busy)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic en, input logic [1:0] vs, input logic [1:0] ms);
        @(negedge clk);
        cfg_we = 1'b1; cfg_enable = en; cfg_reset = 1'b0;
        cfg_vfilt = vs; cfg_mfilt = ms; cfg_match = MATCHES;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_code(input logic [5:0] code, input bit gaps);
        logic [15:0] w;
        w = {1'b0, code, 1'b0, 8'hFF};
        for (int i = 15; i >= 0; i--) begin
            if (gaps && (i % 3 == 0)) begin
                @(negedge clk); fdl_en = 1'b0; fdl_bit = 1'b1;
            end
            @(negedge clk); fdl_en = 1'b1; fdl_bit = w[i];
        end
        @(negedge clk); fdl_en = 1'b0; fdl_bit = 1'b0;
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); fdl_en = 1'b1; fdl_bit = 1'b0;
        end
        @(negedge clk); fdl_en = 1'b0;
    endtask

    task automatic w1c(input logic [3:0] v);
        @(negedge clk); sticky_clr = v;
        @(negedge clk); sticky_clr = '0;
    endtask

    task automatic t_reset_state();
        chk("R11 valid_code", valid_code, 0);
        chk("R11 alarm", alarm, 0);
        chk("R11 match_evt", match_evt, 0);
        chk("R11 irq", {irq_match, irq_alarm}, 0);
        chk("R11 sticky", sticky, 0);
        chk("R11 reset_busy", reset_busy, 0);
    endtask

    task automatic t_no_filter_and_gap();
        cfg(1'b1, 2'b00, 2'b00);
        send_code(6'h12, 1'b0);
        exp_valid = 6'h12;
        chk("R1 R2 valid_code single code", valid_code, exp_valid);
        chk("R2 alarm single code", alarm, 1);
        chk("R3 match_evt m1", match_evt, 3'b010);
        chk("R8 irq_alarm pulse", irq_alarm, 1);
        chk("R8 irq_match pulse", irq_match, 3'b010);
        @(negedge clk);
        chk("R8 irq pulse ends", {irq_match, irq_alarm}, 0);
        chk("R8 sticky set", sticky, 4'b0101);
        send_idle(15);
        chk("R6 alarm held after 15 bits", alarm, 1);
        chk("R6 match held after 15 bits", match_evt, 3'b010);
        send_idle(1);
        chk("R6 alarm cleared at 16 bits", alarm, 0);
        chk("R6 match cleared at 16 bits", match_evt, 0);
        chk("R6 valid_code kept", valid_code, exp_valid);
        w1c(4'b0001);
        chk("R9 w1c clears only bit0", sticky, 4'b0100);
    endtask

    task automatic t_strobe_gaps();
        send_code(6'h2B, 1'b1);
        exp_valid = 6'h2B;
        chk("R1 code with strobe gaps and MSB order", valid_code, exp_valid);
        send_idle(16);
    endtask

    task automatic t_valid_filter_change();
        cfg(1'b1, 2'b01, 2'b00);
        send_code(6'h0C, 1'b0);
        send_code(6'h0C, 1'b0);
        chk("R2 vfilt=01 two codes no alarm", alarm, 0);
        chk("R2 vfilt=01 two codes valid held", valid_code, exp_valid);
        send_code(6'h0C, 1'b0);
        exp_valid = 6'h0C;
        chk("R2 vfilt=01 third code alarm", alarm, 1);
        chk("R2 vfilt=01 third code valid", valid_code, exp_valid);
        send_code(6'h33, 1'b0);
        send_code(6'h33, 1'b0);
        chk("R5 changed code restarts count", valid_code, exp_valid);
        send_code(6'h33, 1'b0);
        exp_valid = 6'h33;
        chk("R5 changed code valid at third repeat", valid_code, exp_valid);
        send_idle(16);
    endtask

    task automatic t_valid_filter_long(input logic [1:0] sel, input int need, input logic [5:0] code);
        cfg(1'b1, sel, 2'b00);
        for (int i = 0; i < need - 1; i++) send_code(code, 1'b0);
        chk("R2 below threshold no alarm", alarm, 0);
        chk("R2 below threshold valid held", valid_code, exp_valid);
        send_code(code, 1'b0);
        exp_valid = code;
        chk("R2 threshold alarm", alarm, 1);
        chk("R2 threshold valid", valid_code, exp_valid);
        send_idle(16);
    endtask

    task automatic t_match_filter();
        cfg(1'b1, 2'b00, 2'b10);
        for (int i = 0; i < 4; i++) send_code(6'h21, 1'b0);
        exp_valid = 6'h21;
        chk("R4 valid path unaffected by match filter", alarm, 1);
        chk("R3 mfilt=10 four codes no match", match_evt, 0);
        send_code(6'h21, 1'b0);
        chk("R3 mfilt=10 fifth code match m2", match_evt, 3'b100);
        chk("R8 irq_match m2", irq_match, 3'b100);
        send_idle(16);
    endtask

    task automatic t_match_independent();
        cfg(1'b1, 2'b11, 2'b00);
        send_code(6'h05, 1'b0);
        chk("R3 R4 match on unvalidated code", match_evt, 3'b001);
        chk("R4 alarm not set by match filter", alarm, 0);
        chk("R4 valid held", valid_code, exp_valid);
        send_idle(16);
    endtask

    task automatic t_disabled();
        cfg(1'b0, 2'b00, 2'b00);
        send_code(6'h12, 1'b0);
        send_code(6'h12, 1'b0);
        chk("R7 disabled alarm", alarm, 0);
        chk("R7 disabled match", match_evt, 0);
        chk("R7 disabled valid held", valid_code, exp_valid);
    endtask

    task automatic t_soft_reset();
        w1c(4'b1111);
        chk("R9 w1c all", sticky, 0);
        cfg(1'b1, 2'b00, 2'b00);
        send_code(6'h12, 1'b0);
        @(negedge clk);
        chk("R8 sticky before reset", sticky, 4'b0101);
        @(negedge clk);
        cfg_we = 1'b1; cfg_reset = 1'b1; cfg_enable = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; cfg_reset = 1'b0;
        chk("R10 reset bit reads 1", reset_busy, 1);
        @(negedge clk);
        chk("R10 reset bit self-clears", reset_busy, 0);
        chk("R10 valid_code default", valid_code, 0);
        chk("R10 alarm default", alarm, 0);
        chk("R10 match default", match_evt, 0);
        chk("R10 sticky kept", sticky, 4'b0101);
        send_code(6'h12, 1'b0);
        chk("R10 enable defaulted off", alarm, 0);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_no_filter_and_gap();
        t_strobe_gaps();
        t_valid_filter_change();
        t_valid_filter_long(2'b10, 5, 6'h1E);
        t_valid_filter_long(2'b11, 7, 6'h39);
        t_match_filter();
        t_match_independent();
        t_disabled();
        t_soft_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule